// File: doc/BRIEF.md
# Multiplexed LCD Waveform Sequencer

This block sequences the drive levels for a four-common, sixteen-segment multiplexed liquid-crystal panel, which gives a matrix of up to 64 segments. A 64-bit register says which segments are lit. The block cycles through the four commons at 1/4 duty. For every pin it emits a 2-bit code that selects one of four analog levels, and those codes steer an external level generator. The polarity inverts on every half-phase, so no pixel carries a net DC voltage.

A run-time select picks one of two schemes. In 1/3 bias, commons and segments both use all four levels. In 1/2 bias, commons use three levels and segments use two, and the frame runs at half the rate. After a reset, or on waking from a clock stop, the block drives a full frame of non-select levels before any common is selected. A display-off input forces the non-select waveform at any time. A separate output-enable per pin tells the pad logic whether the pin is driving the panel or is free to serve as a general port. The pins carry no data stream, so there is no valid/ready handshake and no back-pressure. Every input is a plain level or a one-cycle pulse.

Top module: `lcd_mux_seq`

## Requirements
- R1: While `lcd_off` is 1, every bit of `com_oe` and `seg_oe` is 0.
- R2: While `lcd_off` is 0, all of `com_oe` and `seg_oe[3:0]` are 1, and `seg_oe[4+k]` equals `seg_port_sel[k]` for k = 0..11.
- R3: Level codes are 0 = ground, 1 = one third (the half level in 1/2 bias), 2 = two thirds, 3 = full. The frame has eight half-phases, numbered 0..7. Half-phase p selects common p/2 (COM1 first). On even half-phases the selected common is at code 3, and on odd half-phases it is at code 0. In 1/3 bias, a non-selected common is at code 1 on even half-phases and code 2 on odd ones.
- R4: In 1/3 bias, for the common selected in slot c, segment s is lit when `seg_on[c*16+s]` is 1. A lit segment drives code 0 on even half-phases and code 3 on odd ones. An unlit segment drives code 2 on even half-phases and code 1 on odd ones.
- R5: In 1/2 bias, a non-selected common is at code 1 and segments use only codes 0 and 3. A lit segment drives the level opposite the selected common, and an unlit segment drives the same level as the selected common.
- R6: Each tick advances a prescaler. A half-phase lasts DIV_THIRD ticks in 1/3 bias and 2*DIV_THIRD ticks in 1/2 bias, so the 1/3-bias frame rate is twice the 1/2-bias rate.
- R7: After reset, or in the cycle after a `wake` pulse, the half-phase is 0. No common is selected, and all segments take their unlit levels for eight full half-phases. Polarity keeps alternating during this time. Selection begins at the next half-phase 0.
- R8: While `disp_off` is 1, the outputs follow the non-select waveform of R7 whatever `seg_on` holds, and the timing keeps running.
- R9: When `wake` and a tick at the last prescaler count fall in the same cycle, `wake` wins. The half-phase returns to 0 and the blanking frame restarts.
- R10: At most one common is at a select level (code 0 or 3) in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake | input | 1 | One-cycle pulse on leaving clock-stop; restarts the sequence |
| tick | input | 1 | Timebase tick, one cycle wide |
| bias_third | input | 1 | 1 = 1/3 bias, 0 = 1/2 bias |
| disp_off | input | 1 | Forces the non-select waveform |
| lcd_off | input | 1 | 1 releases every pin to port use |
| seg_port_sel | input | 12 | Per-pin segment enable for S5..S16 (bit 0 = S5) |
| seg_on | input | 64 | Lit pattern, bit c*16+s = common c, segment s |
| com_lvl | output | 8 | Level code per common, COM1 in bits 1:0 |
| seg_lvl | output | 32 | Level code per segment, S1 in bits 1:0 |
| com_oe | output | 4 | Common pin drives the panel |
| seg_oe | output | 16 | Segment pin drives the panel |

## Verification
The case that matters most is a `wake` pulse that lands in the same cycle as the tick that ends a half-phase. Two updates collide in that cycle: the phase advance and the sequence restart. The bench steps the prescaler to its last count, then raises `tick` and `wake` together. It then checks for the blanked half-phase-0 levels, and four ticks later for the blanked odd levels. A design that lets the advance through would already be one half-phase ahead. A second overlap is `disp_off` on top of an otherwise selected slot. Table rows with that bit set must show only non-select levels, even with every segment lit.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;
  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_GND  = 2'd0;
  localparam lvl_t LVL_LO   = 2'd1;
  localparam lvl_t LVL_HI   = 2'd2;
  localparam lvl_t LVL_FULL = 2'd3;

  // Level of a common pin for a given half-phase polarity.
  function automatic lvl_t com_level(input logic third, input logic sel, input logic pol);
    if (sel)        return pol ? LVL_GND : LVL_FULL;
    else if (third) return pol ? LVL_HI  : LVL_LO;
    else            return LVL_LO;
  endfunction

  // Level of a segment pin; lit segments oppose the selected common.
  function automatic lvl_t seg_level(input logic third, input logic lit, input logic pol);
    if (lit)        return pol ? LVL_FULL : LVL_GND;
    else if (third) return pol ? LVL_LO   : LVL_HI;
    else            return pol ? LVL_GND  : LVL_FULL;
  endfunction
endpackage

// File: rtl/lcd_timebase.sv
module lcd_timebase #(
  parameter int DIV_THIRD = 4,
  parameter int SLOT_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake,
  input  logic              tick,
  input  logic              bias_third,
  output logic [SLOT_W-1:0] slot,
  output logic              pol,
  output logic              blank
);
  localparam int CNT_W = $clog2(2 * DIV_THIRD) + 1;
  localparam int PH_W  = SLOT_W + 1;
  localparam logic [CNT_W-1:0] TERM_THIRD = CNT_W'(DIV_THIRD - 1);
  localparam logic [CNT_W-1:0] TERM_HALF  = CNT_W'(2 * DIV_THIRD - 1);

  logic [CNT_W-1:0] cnt;
  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] term;

  assign term = bias_third ? TERM_THIRD : TERM_HALF;

  always_ff @(posedge clk) begin
    if (!rst_n || wake) begin
      cnt   <= '0;
      phase <= '0;
      blank <= 1'b1;
    end else if (tick) begin
      if (cnt >= term) begin
        cnt   <= '0;
        phase <= phase + 1'b1;
        if (&phase) blank <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign slot = phase[PH_W-1:1];
  assign pol  = phase[0];
endmodule

// File: rtl/lcd_com_drv.sv
module lcd_com_drv
  import lcd_mux_pkg::*;
#(
  parameter int NCOM   = 4,
  parameter int SLOT_W = 2
) (
  input  logic              third,
  input  logic              quiet,
  input  logic [SLOT_W-1:0] slot,
  input  logic              pol,
  output logic [2*NCOM-1:0] com_lvl
);
  for (genvar c = 0; c < NCOM; c++) begin : g_com
    logic sel;
    assign sel = !quiet && (slot == SLOT_W'(c));
    assign com_lvl[2*c +: 2] = com_level(third, sel, pol);
  end
endmodule

// File: rtl/lcd_seg_drv.sv
module lcd_seg_drv
  import lcd_mux_pkg::*;
#(
  parameter int NCOM   = 4,
  parameter int NSEG   = 16,
  parameter int SLOT_W = 2
) (
  input  logic                 third,
  input  logic                 quiet,
  input  logic [SLOT_W-1:0]    slot,
  input  logic                 pol,
  input  logic [NCOM*NSEG-1:0] seg_on,
  output logic [2*NSEG-1:0]    seg_lvl
);
  logic [NSEG-1:0] row;

  always_comb begin
    row = '0;
    for (int c = 0; c < NCOM; c++)
      if (slot == SLOT_W'(c)) row = seg_on[c*NSEG +: NSEG];
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign seg_lvl[2*s +: 2] = seg_level(third, !quiet && row[s], pol);
  end
endmodule

// File: rtl/lcd_pin_mux.sv
module lcd_pin_mux #(
  parameter int NCOM   = 4,
  parameter int NSEG   = 16,
  parameter int NFIXED = 4
) (
  input  logic                   lcd_off,
  input  logic [NSEG-NFIXED-1:0] seg_port_sel,
  output logic [NCOM-1:0]        com_oe,
  output logic [NSEG-1:0]        seg_oe
);
  assign com_oe = {NCOM{!lcd_off}};
  assign seg_oe = lcd_off ? '0 : {seg_port_sel, {NFIXED{1'b1}}};
endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq #(
  parameter int NCOM      = 4,
  parameter int NSEG      = 16,
  parameter int NFIXED    = 4,
  parameter int DIV_THIRD = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wake,
  input  logic                   tick,
  input  logic                   bias_third,
  input  logic                   disp_off,
  input  logic                   lcd_off,
  input  logic [NSEG-NFIXED-1:0] seg_port_sel,
  input  logic [NCOM*NSEG-1:0]   seg_on,
  output logic [2*NCOM-1:0]      com_lvl,
  output logic [2*NSEG-1:0]      seg_lvl,
  output logic [NCOM-1:0]        com_oe,
  output logic [NSEG-1:0]        seg_oe
);
  localparam int SLOT_W = $clog2(NCOM);

  logic [SLOT_W-1:0] slot;
  logic              pol;
  logic              blank;
  logic              quiet;

  assign quiet = blank || disp_off;

  lcd_timebase #(.DIV_THIRD(DIV_THIRD), .SLOT_W(SLOT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .wake(wake), .tick(tick),
    .bias_third(bias_third), .slot(slot), .pol(pol), .blank(blank)
  );

  lcd_com_drv #(.NCOM(NCOM), .SLOT_W(SLOT_W)) u_com (
    .third(bias_third), .quiet(quiet), .slot(slot), .pol(pol), .com_lvl(com_lvl)
  );

  lcd_seg_drv #(.NCOM(NCOM), .NSEG(NSEG), .SLOT_W(SLOT_W)) u_seg (
    .third(bias_third), .quiet(quiet), .slot(slot), .pol(pol),
    .seg_on(seg_on), .seg_lvl(seg_lvl)
  );

  lcd_pin_mux #(.NCOM(NCOM), .NSEG(NSEG), .NFIXED(NFIXED)) u_mux (
    .lcd_off(lcd_off), .seg_port_sel(seg_port_sel), .com_oe(com_oe), .seg_oe(seg_oe)
  );
endmodule

// File: rtl/lcd_mux_seq_chk.sv
module lcd_mux_seq_chk #(
  parameter int NCOM   = 4,
  parameter int NSEG   = 16,
  parameter int NFIXED = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wake,
  input logic              bias_third,
  input logic              disp_off,
  input logic              lcd_off,
  input logic [2*NCOM-1:0] com_lvl,
  input logic [2*NSEG-1:0] seg_lvl,
  input logic [NCOM-1:0]   com_oe,
  input logic [NSEG-1:0]   seg_oe
);
  logic [NCOM-1:0] com_sel;
  for (genvar c = 0; c < NCOM; c++) begin : g_c
    assign com_sel[c] = (com_lvl[2*c +: 2] == 2'd0) || (com_lvl[2*c +: 2] == 2'd3);
  end

  assert_oe_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_off |-> (com_oe == '0) && (seg_oe == '0));

  assert_oe_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_off |-> (&com_oe) && (&seg_oe[NFIXED-1:0]));

  assert_single_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(com_sel));

  assert_disp_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    disp_off |-> (com_sel == '0));

  assert_wake_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (com_sel == '0));

  for (genvar s = 0; s < NSEG; s++) begin : g_s
    assert_half_two_levels_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bias_third |-> (seg_lvl[2*s +: 2] == 2'd0) || (seg_lvl[2*s +: 2] == 2'd3));
  end
endmodule

bind lcd_mux_seq lcd_mux_seq_chk #(.NCOM(NCOM), .NSEG(NSEG), .NFIXED(NFIXED)) u_chk (
  .clk(clk), .rst_n(rst_n), .wake(wake), .bias_third(bias_third),
  .disp_off(disp_off), .lcd_off(lcd_off), .com_lvl(com_lvl), .seg_lvl(seg_lvl),
  .com_oe(com_oe), .seg_oe(seg_oe)
);

// File: tb/tb_lcd_mux_seq.sv
module tb_lcd_mux_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wake = 1'b0;
  logic        tick = 1'b0;
  logic        bias_third = 1'b1;
  logic        disp_off = 1'b0;
  logic        lcd_off = 1'b0;
  logic [11:0] seg_port_sel = '0;
  logic [63:0] seg_on = '0;
  logic [7:0]  com_lvl;
  logic [31:0] seg_lvl;
  logic [3:0]  com_oe;
  logic [15:0] seg_oe;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  lcd_mux_seq dut (
    .clk(clk), .rst_n(rst_n), .wake(wake), .tick(tick), .bias_third(bias_third),
    .disp_off(disp_off), .lcd_off(lcd_off), .seg_port_sel(seg_port_sel),
    .seg_on(seg_on), .com_lvl(com_lvl), .seg_lvl(seg_lvl),
    .com_oe(com_oe), .seg_oe(seg_oe)
  );

  // {bias_third, disp_off, half-phase, seg_on}
  localparam logic [68:0] VEC [7] = '{
    {1'b1, 1'b0, 3'd0, 64'h0000_0000_0000_FFFF},
    {1'b1, 1'b0, 3'd3, 64'hA5A5_0F0F_1234_8001},
    {1'b1, 1'b0, 3'd6, 64'hFFFF_0000_FFFF_0000},
    {1'b0, 1'b0, 3'd1, 64'h0001_8000_00FF_F00F},
    {1'b0, 1'b0, 3'd4, 64'hDEAD_BEEF_CAFE_F00D},
    {1'b1, 1'b1, 3'd5, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b0, 1'b1, 3'd2, 64'hFFFF_FFFF_FFFF_FFFF}
  };

  // Expected {com_lvl, seg_lvl} from the level rules of R3, R4, R5, R7, R8.
  function automatic logic [39:0] model(input logic third, input logic quiet,
                                        input logic [2:0] ph, input logic [63:0] on);
    logic [7:0]  ec;
    logic [31:0] es;
    logic odd;
    odd = ph[0];
    for (int c = 0; c < 4; c++) begin
      if (!quiet && c == int'(ph[2:1])) ec[2*c +: 2] = odd ? 2'd0 : 2'd3;
      else if (third)                   ec[2*c +: 2] = odd ? 2'd2 : 2'd1;
      else                              ec[2*c +: 2] = 2'd1;
    end
    for (int s = 0; s < 16; s++) begin
      if (!quiet && on[int'(ph[2:1])*16 + s]) es[2*s +: 2] = odd ? 2'd3 : 2'd0;
      else if (third)                          es[2*s +: 2] = odd ? 2'd1 : 2'd2;
      else                                     es[2*s +: 2] = odd ? 2'd0 : 2'd3;
    end
    return {ec, es};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic do_wake();
    @(negedge clk) wake = 1'b1;
    @(negedge clk) wake = 1'b0;
  endtask

  initial begin
    #2_000_000ns;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: reset state is blanked half-phase 0
    check("R7 reset", {24'd0, com_lvl, seg_lvl}, {24'd0, model(1'b1, 1'b1, 3'd0, seg_on)});

    // R1 and R2: pin ownership
    lcd_off = 1'b1; seg_port_sel = 12'hA53;
    @(negedge clk);
    check("R1", {44'd0, com_oe, seg_oe}, 64'd0);
    lcd_off = 1'b0;
    @(negedge clk);
    check("R2", {44'd0, com_oe, seg_oe}, {44'd0, 4'hF, 12'hA53, 4'hF});

    // Table: R3 R4 R5 R8 under several patterns
    foreach (VEC[v]) begin
      int div;
      bias_third = VEC[v][68];
      disp_off   = VEC[v][67];
      seg_on     = VEC[v][63:0];
      div = bias_third ? 4 : 8;
      do_wake();
      ticks((8 + int'(VEC[v][66:64])) * div);
      check(disp_off ? "R8" : (bias_third ? "R3 R4" : "R3 R5"),
            {24'd0, com_lvl, seg_lvl},
            {24'd0, model(bias_third, disp_off, VEC[v][66:64], seg_on)});
    end
    disp_off = 1'b0;
    seg_on = 64'h0123_4567_89AB_CDEF;

    // R7: blanking lasts all eight half-phases, then selection starts
    bias_third = 1'b1;
    do_wake();
    ticks(7 * 4);
    check("R7 last blank", {24'd0, com_lvl, seg_lvl}, {24'd0, model(1'b1, 1'b1, 3'd7, seg_on)});
    ticks(4);
    check("R7 first select", {24'd0, com_lvl, seg_lvl}, {24'd0, model(1'b1, 1'b0, 3'd0, seg_on)});

    // R6: 1/3 bias half-phase is 4 ticks
    ticks(3);
    check("R6 third hold", {56'd0, com_lvl}, {56'd0, 8'h57});
    ticks(1);
    check("R6 third step", {56'd0, com_lvl}, {56'd0, 8'hA8});
    // R6: 1/2 bias half-phase is 8 ticks
    bias_third = 1'b0;
    do_wake();
    ticks(64);
    ticks(7);
    check("R6 half hold", {56'd0, com_lvl}, {56'd0, 8'h57});
    ticks(1);
    check("R6 half step", {56'd0, com_lvl}, {56'd0, 8'h54});

    // R9: wake together with the terminal tick
    bias_third = 1'b1;
    do_wake();
    ticks(3);
    @(negedge clk) begin tick = 1'b1; wake = 1'b1; end
    @(negedge clk) begin tick = 1'b0; wake = 1'b0; end
    check("R9 restart", {24'd0, com_lvl, seg_lvl}, {24'd0, model(1'b1, 1'b1, 3'd0, seg_on)});
    ticks(4);
    check("R9 next", {24'd0, com_lvl, seg_lvl}, {24'd0, model(1'b1, 1'b1, 3'd1, seg_on)});
    // R10 is held by the bound checker during all of the above

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule